// File: doc/BRIEF.md
# Packed Lane Permute and Pack Unit

This unit rearranges the lanes of two 64-bit packed operands into one 64-bit result. It has three operations. A shuffle builds each result lane from a lane chosen by a small selector packed into an 8-bit control byte; selector values past the end of the first operand reach into the second. An unpack interleaves lanes taken from either the low or the high half of both operands. A pack narrows every lane of both operands to half its width, saturating values that do not fit, with distinct clamping for signed and unsigned targets.

All inputs are sampled together on a valid strobe. The result register and a one-cycle completion pulse appear one clock later. An illegal combination of opcode and lane sizes raises an error flag alongside the completion pulse and leaves the result register untouched.

The control is a three-state machine: `ST_IDLE` (nothing completed last cycle), `ST_DONE` (a legal operation completed) and `ST_FAULT` (an illegal request was refused). From any state, a strobe with a legal request moves to `ST_DONE` and a strobe with an illegal request moves to `ST_FAULT`. A cycle without a strobe returns to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `lane_perm_unit`

## Requirements
- R1: While reset is asserted and after its release, the result is 0 and both the completion and error outputs are low until the first strobe is taken.
- R2: A strobe on `in_valid` at clock edge k makes `done` high for exactly the cycle after edge k, with the new `result` visible in that same cycle. Back-to-back strobes give back-to-back completions in order.
- R3: Opcode 0 is shuffle, and it requires `src_sz == dst_sz`. Size codes 0, 1, 2 and 3 mean 1-, 2-, 4- and 8-byte lanes. With 1-, 2- or 4-byte lanes each result lane uses a 2-bit selector, and with 8-byte lanes a 1-bit selector. Selectors are read from bit 0 of `ext` upward, result lane 0 first. Selector bits beyond bit 7 read as zero.
- R4: In a shuffle, a selector at least equal to the lane count of the register takes lane (selector minus half the number of selector choices) of `opb`. Any smaller selector takes that lane of `opa`.
- R5: Opcode 1 is unpack, and it requires equal sizes of 1, 2 or 4 bytes. With `ext` zero it uses the low half of each operand's lanes, and with `ext` nonzero it uses the high half. Result lane 2i is the i-th selected lane of `opa` and result lane 2i+1 is the i-th selected lane of `opb`.
- R6: Opcode 2 is pack, and it requires source lanes exactly twice as wide as destination lanes, with destination lanes of 1, 2 or 4 bytes. The lower half of the result holds the narrowed lanes of `opa` in ascending order, and the upper half holds those of `opb`.
- R7: In a signed pack (`sgn`=1), a negative source that does not fit becomes the most negative destination value. A non-negative source that does not fit becomes the most positive destination value.
- R8: In an unsigned pack (`sgn`=0), the source is still read as signed. A negative source that does not fit becomes 0, and a non-negative source that does not fit becomes all ones.
- R9: A source fits when every bit from the destination sign position up to the source sign bit equals the source sign bit. A source that fits is passed through truncated to the destination width, in both signed and unsigned packs.
- R10: Opcode 3, a shuffle or unpack with unequal sizes, an unpack of 8-byte lanes, and a pack with any other size pairing are illegal. For an illegal request, `err` and `done` are high together for one cycle and `result` keeps its previous value.
- R11: In a cycle after which no strobe was taken, `done` and `err` are low and `result` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: sample all request inputs this edge |
| op | input | 2 | 0 shuffle, 1 unpack, 2 pack, 3 reserved |
| src_sz | input | 2 | Source lane size code (bytes = 1 << code) |
| dst_sz | input | 2 | Destination lane size code (bytes = 1 << code) |
| ext | input | 8 | Shuffle selectors, or unpack half select |
| sgn | input | 1 | Signed saturation for pack |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| result | output | 64 | Registered result |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request, valid with done |

## Verification
The bound checker watches the protocol on every cycle. It checks that a strobe is always followed by a completion pulse and that no pulse appears without one. It also checks that the result holds on idle and refused cycles, that an error never appears without a completion, and that reserved opcodes and mismatched shuffle sizes are refused. The lane arithmetic itself can only be shown by the bench's scenarios. These cover the selector order and the reach into the second operand, low- and high-half interleaving, pack ordering, the signed and unsigned clamps at both boundaries, and in-range values that pass through, all compared against an independent lane model.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
    typedef enum logic [1:0] {
        OP_SHUF = 2'd0,
        OP_UNPK = 2'd1,
        OP_PACK = 2'd2,
        OP_RSVD = 2'd3
    } perm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } perm_st_e;

    localparam int NUM_SZ = 4;
endpackage

// File: rtl/lane_shuffle.sv
module lane_shuffle #(
    parameter int DW   = 64,
    parameter int SELW = 8
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [1:0]      sz,
    input  logic [SELW-1:0] sel,
    output logic [DW-1:0]   y
);
    import lane_perm_pkg::*;

    logic [DW-1:0] cand [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
        localparam int LW  = 8 << g;
        localparam int NL  = DW / LW;
        localparam int OB  = (g == NUM_SZ - 1) ? 1 : 2;
        localparam int OPT = 1 << OB;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            logic [OB-1:0] s_i;
            logic [LW-1:0] lane_v;
            assign s_i = OB'(sel >> (i * OB));
            always_comb begin
                if (int'(s_i) >= NL) begin
                    lane_v = b[(int'(s_i) - OPT / 2) * LW +: LW];
                end else begin
                    lane_v = a[int'(s_i) * LW +: LW];
                end
            end
            assign cand[g][i*LW +: LW] = lane_v;
        end
    end

    assign y = cand[sz];
endmodule

// File: rtl/lane_unpack.sv
module lane_unpack #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    sz,
    input  logic          hi,
    output logic [DW-1:0] y
);
    import lane_perm_pkg::*;

    logic [DW-1:0] cand [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ - 1; g++) begin : g_sz
        localparam int LW   = 8 << g;
        localparam int HALF = (DW / LW) / 2;
        for (genvar i = 0; i < HALF; i++) begin : g_lane
            assign cand[g][(2*i)*LW +: LW]   = hi ? a[(i+HALF)*LW +: LW] : a[i*LW +: LW];
            assign cand[g][(2*i+1)*LW +: LW] = hi ? b[(i+HALF)*LW +: LW] : b[i*LW +: LW];
        end
    end
    assign cand[NUM_SZ-1] = '0;

    assign y = cand[sz];
endmodule

// File: rtl/lane_sat.sv
module lane_sat #(
    parameter int DLW = 8
) (
    input  logic [2*DLW-1:0] v,
    input  logic             sgn,
    output logic [DLW-1:0]   o
);
    logic         neg;
    logic [DLW:0] upper;
    logic         fits;

    assign neg   = v[2*DLW-1];
    assign upper = v[2*DLW-1:DLW-1];
    assign fits  = neg ? (&upper) : ~(|upper);

    always_comb begin
        if (fits) begin
            o = v[DLW-1:0];
        end else if (sgn) begin
            o = neg ? {1'b1, {(DLW-1){1'b0}}} : {1'b0, {(DLW-1){1'b1}}};
        end else begin
            o = neg ? '0 : '1;
        end
    end
endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    dsz,
    input  logic          sgn,
    output logic [DW-1:0] y
);
    import lane_perm_pkg::*;

    logic [DW-1:0] cand [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ - 1; g++) begin : g_sz
        localparam int DLW = 8 << g;
        localparam int SLW = 2 * DLW;
        localparam int NS  = DW / SLW;
        for (genvar j = 0; j < NS; j++) begin : g_lane
            lane_sat #(.DLW(DLW)) u_sat_a (
                .v   (a[j*SLW +: SLW]),
                .sgn (sgn),
                .o   (cand[g][j*DLW +: DLW])
            );
            lane_sat #(.DLW(DLW)) u_sat_b (
                .v   (b[j*SLW +: SLW]),
                .sgn (sgn),
                .o   (cand[g][(NS+j)*DLW +: DLW])
            );
        end
    end
    assign cand[NUM_SZ-1] = '0;

    assign y = cand[dsz];
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit #(
    parameter int DW   = 64,
    parameter int SELW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [1:0]      src_sz,
    input  logic [1:0]      dst_sz,
    input  logic [SELW-1:0] ext,
    input  logic            sgn,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [DW-1:0]   result,
    output logic            done,
    output logic            err
);
    import lane_perm_pkg::*;

    localparam logic [1:0] SZ_MAX = 2'(NUM_SZ - 1);

    perm_st_e      cur_st, nxt_st;
    logic          legal;
    logic [DW-1:0] shuf_y, unpk_y, pack_y, next_res;

    lane_shuffle #(.DW(DW), .SELW(SELW)) u_shuf (
        .a(opa), .b(opb), .sz(src_sz), .sel(ext), .y(shuf_y)
    );

    lane_unpack #(.DW(DW)) u_unpk (
        .a(opa), .b(opb), .sz(src_sz), .hi(|ext), .y(unpk_y)
    );

    lane_pack #(.DW(DW)) u_pack (
        .a(opa), .b(opb), .dsz(dst_sz), .sgn(sgn), .y(pack_y)
    );

    // Legality of the request and the value it would commit
    always_comb begin
        legal    = 1'b0;
        next_res = result;
        unique case (perm_op_e'(op))
            OP_SHUF: begin
                legal    = (src_sz == dst_sz);
                next_res = shuf_y;
            end
            OP_UNPK: begin
                legal    = (src_sz == dst_sz) && (src_sz != SZ_MAX);
                next_res = unpk_y;
            end
            OP_PACK: begin
                legal    = (dst_sz != SZ_MAX) && (src_sz == dst_sz + 2'd1);
                next_res = pack_y;
            end
            OP_RSVD: begin
                legal    = 1'b0;
                next_res = result;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt_st = ST_IDLE;
        unique case (cur_st)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (in_valid) begin
                    nxt_st = legal ? ST_DONE : ST_FAULT;
                end else begin
                    nxt_st = ST_IDLE;
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid && legal) begin
            result <= next_res;
        end
    end

    // Outputs decoded from state
    always_comb begin
        done = 1'b0;
        err  = 1'b0;
        unique case (cur_st)
            ST_IDLE:  begin done = 1'b0; err = 1'b0; end
            ST_DONE:  begin done = 1'b1; err = 1'b0; end
            ST_FAULT: begin done = 1'b1; err = 1'b1; end
            default:  begin done = 1'b0; err = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lane_perm_unit_chk.sv
module lane_perm_unit_chk #(
    parameter int DW   = 64,
    parameter int SELW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      op,
    input logic [1:0]      src_sz,
    input logic [1:0]      dst_sz,
    input logic [SELW-1:0] ext,
    input logic            sgn,
    input logic [DW-1:0]   opa,
    input logic [DW-1:0]   opb,
    input logic [DW-1:0]   result,
    input logic            done,
    input logic            err
);
    AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);                                                   // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !err));                                       // R11
    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));                                       // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);                                                        // R10
    AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(result));                                             // R10
    AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd3) |=> err);                                    // R10
    AST_SHUF_SIZE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && src_sz != dst_sz) |=> err);                // R10
endmodule

bind lane_perm_unit lane_perm_unit_chk #(.DW(DW), .SELW(SELW)) u_chk (.*);

// File: tb/lane_perm_unit_tb.sv
module lane_perm_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0, src_sz = '0, dst_sz = '0;
    logic [7:0]  ext = '0;
    logic        sgn = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [63:0] result;
    logic        done, err;

    int checks = 0;
    int errors = 0;
    logic [63:0] model_res = '0;

    logic [63:0] q_res[$];
    logic        q_err[$];
    string       q_tag[$];

    lane_perm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_sz(src_sz), .dst_sz(dst_sz), .ext(ext), .sgn(sgn),
        .opa(opa), .opb(opb), .result(result), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] mk(int w);
        return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] getl(logic [63:0] x, int k, int w);
        return (x >> (k * w)) & mk(w);
    endfunction

    function automatic logic [63:0] putl(logic [63:0] x, int k, int w, logic [63:0] v);
        return (x & ~(mk(w) << (k * w))) | ((v & mk(w)) << (k * w));
    endfunction

    // Independent lane model built from the requirement list
    task automatic model(input logic [1:0] o, input logic [1:0] ss, input logic [1:0] ds,
                         input logic [7:0] e, input logic s, input logic [63:0] a,
                         input logic [63:0] b, output logic ok, output logic [63:0] r);
        r  = '0;
        ok = 1'b0;
        if (o == 2'd0 && ss == ds) begin
            int w = 8 << ss;
            int n = 64 / w;
            int ob = (ss == 2'd3) ? 1 : 2;
            int nopt = 1 << ob;
            int selv = int'(e);
            ok = 1'b1;
            for (int i = 0; i < n; i++) begin
                int pick = selv & (nopt - 1);
                selv = selv >> ob;
                if (pick >= n) r = putl(r, i, w, getl(b, pick - nopt / 2, w));
                else           r = putl(r, i, w, getl(a, pick, w));
            end
        end else if (o == 2'd1 && ss == ds && ss != 2'd3) begin
            int w = 8 << ss;
            int half = (64 / w) / 2;
            int off = (e != 0) ? half : 0;
            ok = 1'b1;
            for (int i = 0; i < half; i++) begin
                r = putl(r, 2 * i, w, getl(a, i + off, w));
                r = putl(r, 2 * i + 1, w, getl(b, i + off, w));
            end
        end else if (o == 2'd2 && ds != 2'd3 && int'(ss) == int'(ds) + 1) begin
            int dw = 8 << ds;
            int sw = 2 * dw;
            int n = 64 / dw;
            ok = 1'b1;
            for (int i = 0; i < n; i++) begin
                logic [63:0] v, up, outv;
                logic neg, fit;
                v   = (i < n / 2) ? getl(a, i, sw) : getl(b, i - n / 2, sw);
                neg = v[sw-1];
                up  = (v >> (dw - 1)) & mk(sw - dw + 1);
                fit = neg ? (up == mk(sw - dw + 1)) : (up == 64'd0);
                if (fit)      outv = v & mk(dw);
                else if (s)   outv = neg ? (64'd1 << (dw - 1)) : mk(dw - 1);
                else          outv = neg ? 64'd0 : mk(dw);
                r = putl(r, i, dw, outv);
            end
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic [1:0] ss, input logic [1:0] ds,
                         input logic [7:0] e, input logic s, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        logic ok;
        logic [63:0] r;
        @(negedge clk);
        op = o; src_sz = ss; dst_sz = ds; ext = e; sgn = s; opa = a; opb = b;
        in_valid = 1'b1;
        model(o, ss, ds, e, s, a, b, ok, r);
        if (ok) model_res = r;
        q_res.push_back(model_res);
        q_err.push_back(!ok);
        q_tag.push_back(tag);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(input bit cond, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R2 unexpected done", {63'd0, done}, 64'd0);
            end else begin
                logic [63:0] er;
                logic ee;
                string t;
                er = q_res.pop_front();
                ee = q_err.pop_front();
                t  = q_tag.pop_front();
                check(result === er, {t, " result"}, result, er);
                check(err === ee, {t, " err"}, {63'd0, err}, {63'd0, ee});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check(result == 64'd0 && !done && !err, "R1 reset state",
              {result[61:0], done, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 64'd0 && !done && !err, "R1 after release",
              {result[61:0], done, err}, 64'd0);

        // R3: 1-byte lanes, selectors 3,2,1,0 then zeros past bit 7
        issue(2'd0, 2'd0, 2'd0, 8'h1B, 1'b0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, "R3 shuffle bytes");
        // R3: 2-byte identity order
        issue(2'd0, 2'd1, 2'd1, 8'hE4, 1'b0, 64'h4444_3333_2222_1111, 64'h0, "R3 shuffle halves");
        // R4: 4-byte selectors 2 and 3 reach the second operand
        issue(2'd0, 2'd2, 2'd2, 8'h0E, 1'b0, 64'h1111_1111_2222_2222, 64'hAAAA_AAAA_BBBB_BBBB, "R4 shuffle words from opb");
        issue(2'd0, 2'd2, 2'd2, 8'h09, 1'b0, 64'h1111_1111_2222_2222, 64'hAAAA_AAAA_BBBB_BBBB, "R4 shuffle mixed words");
        issue(2'd0, 2'd3, 2'd3, 8'h01, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R4 shuffle dword from opb");
        issue(2'd0, 2'd3, 2'd3, 8'h00, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R4 shuffle dword from opa");
        // R5: unpack low and high halves
        issue(2'd1, 2'd0, 2'd0, 8'h00, 1'b0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "R5 unpack bytes low");
        issue(2'd1, 2'd0, 2'd0, 8'h05, 1'b0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "R5 unpack bytes high");
        issue(2'd1, 2'd2, 2'd2, 8'h80, 1'b0, 64'h1111_1111_2222_2222, 64'h3333_3333_4444_4444, "R5 unpack words high");
        quiet(1);
        // R6 R7 R9: signed 16->8
        issue(2'd2, 2'd1, 2'd0, 8'h00, 1'b1, 64'h8000_0100_FF80_0005, 64'h007F_FF7F_7FFF_FFFF, "R7 signed pack 16to8");
        // R8 R9: unsigned 16->8
        issue(2'd2, 2'd1, 2'd0, 8'h00, 1'b0, 64'h8000_0100_FF80_0080, 64'h007F_FFFF_0001_7FFF, "R8 unsigned pack 16to8");
        // R6: 32->16 and 64->32 ordering and clamps
        issue(2'd2, 2'd2, 2'd1, 8'h00, 1'b1, 64'h0000_1234_FFFF_8000, 64'h0001_0000_8000_0000, "R6 signed pack 32to16");
        issue(2'd2, 2'd3, 2'd2, 8'h00, 1'b0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, "R6 unsigned pack 64to32");
        issue(2'd2, 2'd3, 2'd2, 8'h00, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF, "R9 signed pack fits");
        // R10: illegal requests keep the result
        issue(2'd3, 2'd0, 2'd0, 8'h00, 1'b0, 64'h1, 64'h2, "R10 reserved opcode");
        issue(2'd0, 2'd1, 2'd2, 8'h00, 1'b0, 64'h1, 64'h2, "R10 shuffle size mismatch");
        issue(2'd1, 2'd3, 2'd3, 8'h00, 1'b0, 64'h1, 64'h2, "R10 unpack 8-byte");
        issue(2'd2, 2'd0, 2'd0, 8'h00, 1'b0, 64'h1, 64'h2, "R10 pack equal sizes");
        issue(2'd2, 2'd2, 2'd0, 8'h00, 1'b0, 64'h1, 64'h2, "R10 pack 4to1");
        // R2: back-to-back after a fault
        issue(2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 64'h0000_0000_0000_00AB, 64'h0, "R2 back-to-back");
        quiet(2);

        // R11: idle cycles hold the result with no pulse
        held = result;
        quiet(3);
        check(result === held && !done && !err, "R11 idle hold", result, held);
        check(q_res.size() == 0, "R2 all completions seen", 64'(q_res.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule